// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a 32-bit processor that executes one instruction per rising clock edge. It fetches the word at the program counter, decodes it and reads two registers. It then computes either an ALU result or a memory address, and commits the result at the next edge. The core implements eight operations: five register-to-register ALU operations (add, subtract, and, or, signed set-less-than), a word load, a word store, and a branch-if-equal.

Instruction and data storage are small word arrays inside the block. Both arrays read combinationally and write on the clock. A loading port fills either array while the core is held in reset. Two inspection ports show one register and one data word combinationally, so the state left by a program can be examined at the ports.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high `rst` sets the program counter to 0 and all 32 registers to 0. While `rst` is high, the core performs no data store.
- R2: The instruction is fetched from the instruction word `pc_o[MEM_AW+1:2]`. Any instruction other than a taken branch sets the next PC to PC+4.
- R3: Opcode 000000 (bits 31:26) writes register rd (bits 15:11). The source registers are rs (bits 25:21) and rt (bits 20:16). The funct field (bits 5:0) selects the operation: 100000 add, 100010 subtract, 100100 and, 100101 or, 101010 signed less-than giving 1 or 0. Any other funct value writes no register.
- R4: Opcode 100011 writes the data word at index `(R[rs]+sext(imm16))[MEM_AW+1:2]` into register rt. The low two address bits are ignored. imm16 is bits 15:0.
- R5: Opcode 101011 stores R[rt] into the data word at the same computed index. It writes no register.
- R6: Opcode 000100 compares R[rs] and R[rt]. If they are equal, the next PC is PC+4+(sext(imm16)<<2); otherwise it is PC+4. It writes no register and no memory.
- R7: Register 0 always reads as zero, and writes to it are discarded.
- R8: Any other opcode changes neither registers nor memory; it only advances the PC by 4.
- R9: When `ld_en` is high, the clock edge writes `ld_data` into word `ld_addr` of the data array if `ld_dmem`=1, or of the instruction array if `ld_dmem`=0. `peek_reg_data` and `peek_mem_data` read combinationally.
- R10: Operands are read before the edge that writes them. An instruction whose destination is also a source therefore uses the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Write one word through the loading port |
| ld_dmem | input | 1 | Loading target: 1 data array, 0 instruction array |
| ld_addr | input | MEM_AW | Word index for the loading port |
| ld_data | input | 32 | Word to load |
| pc_o | output | 32 | Current program counter |
| peek_reg | input | 5 | Register index to inspect |
| peek_reg_data | output | 32 | Value of the inspected register |
| peek_addr | input | MEM_AW | Data word index to inspect |
| peek_mem_data | output | 32 | Value of the inspected data word |

## Verification
A wrong next-PC value shows on `pc_o` one edge after the faulty instruction, and every later fetch then diverges. A wrong register or stored word shows on the inspection ports right after that edge. It also spreads into the PC once a later branch reads the bad value. The bench runs directed and random programs against an instruction-level model for a fixed number of edges. It then compares the PC, every register and every data word.

// File: rtl/sc_pkg.sv
package sc_pkg;
    localparam int XLEN    = 32;
    localparam int REG_CNT = 32;
    localparam int RIDX_W  = $clog2(REG_CNT);

    typedef logic [XLEN-1:0]   word_t;
    typedef logic [RIDX_W-1:0] ridx_t;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_LOAD  = 6'b100011;
    localparam logic [5:0] OP_STORE = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    // operation class chosen by the main decoder, refined by funct
    typedef enum logic [1:0] {
        CLS_MEM   = 2'b00,
        CLS_CMP   = 2'b01,
        CLS_FUNCT = 2'b10,
        CLS_NONE  = 2'b11
    } alu_class_e;

    typedef enum logic [2:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_NOP = 3'b011,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_fn_e;

    typedef struct packed {
        logic [5:0] op;
        ridx_t      rs;
        ridx_t      rt;
        ridx_t      rd;
        logic [4:0] shamt;
        logic [5:0] funct;
    } rfmt_t;

    typedef struct packed {
        logic       dst_rd;
        logic       reg_we;
        logic       src_imm;
        logic       branch;
        logic       mem_rd;
        logic       mem_we;
        logic       wb_mem;
        alu_class_e cls;
    } ctrl_t;

    function automatic word_t sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction
endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctl,
    output alu_fn_e    alu_fn
);
    always_comb begin
        ctl     = '0;
        ctl.cls = CLS_NONE;
        case (op)
            OP_RTYPE: begin
                ctl.cls    = CLS_FUNCT;
                ctl.dst_rd = 1'b1;
            end
            OP_LOAD: begin
                ctl.cls     = CLS_MEM;
                ctl.src_imm = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.mem_rd  = 1'b1;
                ctl.wb_mem  = 1'b1;
            end
            OP_STORE: begin
                ctl.cls     = CLS_MEM;
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OP_BEQ: begin
                ctl.cls    = CLS_CMP;
                ctl.branch = 1'b1;
            end
            default: ;
        endcase

        case (ctl.cls)
            CLS_MEM: alu_fn = ALU_ADD;
            CLS_CMP: alu_fn = ALU_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  alu_fn = ALU_ADD;
                    FN_SUB:  alu_fn = ALU_SUB;
                    FN_AND:  alu_fn = ALU_AND;
                    FN_OR:   alu_fn = ALU_OR;
                    FN_SLT:  alu_fn = ALU_SLT;
                    default: alu_fn = ALU_NOP;
                endcase
            end
            default: alu_fn = ALU_NOP;
        endcase

        if (ctl.cls == CLS_FUNCT) begin
            ctl.reg_we = (alu_fn != ALU_NOP);
        end
    end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
    import sc_pkg::*;
(
    input  word_t   a,
    input  word_t   b,
    input  alu_fn_e fn,
    output word_t   y,
    output logic    zero
);
    always_comb begin
        case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end
    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile
    import sc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ridx_t ra,
    input  ridx_t rb,
    input  ridx_t rc,
    input  ridx_t rw,
    input  logic  we,
    input  word_t wd,
    output word_t qa,
    output word_t qb,
    output word_t qc
);
    word_t regs [REG_CNT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < REG_CNT; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (rw != '0)) begin
            regs[rw] <= wd;
        end
    end

    assign qa = (ra == '0) ? '0 : regs[ra];
    assign qb = (rb == '0) ? '0 : regs[rb];
    assign qc = (rc == '0) ? '0 : regs[rc];
endmodule

// File: rtl/sc_mem.sv
module sc_mem
    import sc_pkg::*;
#(
    parameter int AW  = 6,
    parameter int NRD = 1,
    localparam int DEPTH = 1 << AW
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  word_t                   wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output word_t [NRD-1:0]         rdata
);
    word_t cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = cells[raddr[p]];
    end
endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_dmem,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    output logic [31:0]       pc_o,
    input  logic [4:0]        peek_reg,
    output logic [31:0]       peek_reg_data,
    input  logic [MEM_AW-1:0] peek_addr,
    output logic [31:0]       peek_mem_data
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = MEM_AW + IDX_LO - 1;

    word_t   pc_q, pc_plus4, br_target, pc_next;
    word_t   instr_w, rs_val, rt_val, imm_ext, alu_b, alu_y, dm_rdata, wb_data;
    rfmt_t   inst;
    ctrl_t   ctl;
    alu_fn_e alu_fn;
    logic    alu_zero, take_br, core_dm_we, rf_we;
    ridx_t   wr_idx;

    logic                     im_we, dm_we;
    logic [MEM_AW-1:0]        dm_waddr;
    word_t                    dm_wdata;
    logic [0:0][MEM_AW-1:0]   im_raddr;
    word_t [0:0]              im_rdata;
    logic [1:0][MEM_AW-1:0]   dm_raddr;
    word_t [1:0]              dm_rdata_v;

    // fetch
    assign im_raddr[0] = pc_q[IDX_HI:IDX_LO];
    assign im_we       = ld_en && !ld_dmem;

    sc_mem #(.AW(MEM_AW), .NRD(1)) u_imem (
        .clk   (clk),
        .we    (im_we),
        .waddr (ld_addr),
        .wdata (ld_data),
        .raddr (im_raddr),
        .rdata (im_rdata)
    );

    assign instr_w = im_rdata[0];
    assign inst    = rfmt_t'(instr_w);

    // decode
    sc_decode u_dec (
        .op     (inst.op),
        .funct  (inst.funct),
        .ctl    (ctl),
        .alu_fn (alu_fn)
    );

    assign wr_idx = ctl.dst_rd ? inst.rd : inst.rt;
    assign rf_we  = ctl.reg_we;

    sc_regfile u_rf (
        .clk (clk),
        .rst (rst),
        .ra  (inst.rs),
        .rb  (inst.rt),
        .rc  (peek_reg),
        .rw  (wr_idx),
        .we  (rf_we),
        .wd  (wb_data),
        .qa  (rs_val),
        .qb  (rt_val),
        .qc  (peek_reg_data)
    );

    // execute
    assign imm_ext = sext16(instr_w[15:0]);
    assign alu_b   = ctl.src_imm ? imm_ext : rt_val;

    sc_alu u_alu (
        .a    (rs_val),
        .b    (alu_b),
        .fn   (alu_fn),
        .y    (alu_y),
        .zero (alu_zero)
    );

    // data memory: loading port has priority, core stores blocked in reset
    assign core_dm_we  = ctl.mem_we && !rst;
    assign dm_we       = (ld_en && ld_dmem) || core_dm_we;
    assign dm_waddr    = (ld_en && ld_dmem) ? ld_addr : alu_y[IDX_HI:IDX_LO];
    assign dm_wdata    = (ld_en && ld_dmem) ? ld_data : rt_val;
    assign dm_raddr[0] = alu_y[IDX_HI:IDX_LO];
    assign dm_raddr[1] = peek_addr;

    sc_mem #(.AW(MEM_AW), .NRD(2)) u_dmem (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (dm_raddr),
        .rdata (dm_rdata_v)
    );

    assign dm_rdata      = dm_rdata_v[0];
    assign peek_mem_data = dm_rdata_v[1];
    assign wb_data       = ctl.wb_mem ? dm_rdata : alu_y;

    // next PC
    assign pc_plus4  = pc_q + 32'd4;
    assign br_target = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
    assign take_br   = ctl.branch && alu_zero;
    assign pc_next   = take_br ? br_target : pc_plus4;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o = pc_q;

    logic unused_bits;
    assign unused_bits = ^{inst.shamt, ctl.mem_rd};
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
    import sc_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        core_dm_we,
    input logic        rf_we,
    input logic [4:0]  peek_reg,
    input logic [31:0] peek_reg_data
);
    logic [5:0]  opc;
    logic [31:0] boff;
    assign opc  = instr[31:26];
    assign boff = {{14{instr[15]}}, instr[15:0], 2'b00};

    // R1
    reset_pc_chk: assert property (@(posedge clk) rst |=> (pc == 32'd0));

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (opc != OP_BEQ) |=> (pc == $past(pc) + 32'd4));

    // R6
    beq_taken_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_BEQ && rs_val == rt_val) |=> (pc == $past(pc) + 32'd4 + $past(boff)));

    // R6
    beq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (opc == OP_BEQ && rs_val != rt_val) |=> (pc == $past(pc) + 32'd4));

    // R5
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        core_dm_we |-> (opc == OP_STORE));

    // R8
    reg_write_src_chk: assert property (@(posedge clk) disable iff (rst)
        rf_we |-> (opc == OP_RTYPE || opc == OP_LOAD));

    // R7
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (peek_reg == 5'd0) |-> (peek_reg_data == 32'd0));
endmodule

bind sc_core sc_core_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .pc            (pc_q),
    .instr         (instr_w),
    .rs_val        (rs_val),
    .rt_val        (rt_val),
    .core_dm_we    (core_dm_we),
    .rf_we         (rf_we),
    .peek_reg      (peek_reg),
    .peek_reg_data (peek_reg_data)
);

// File: tb/sc_core_bench.sv
`timescale 1ns/1ps
module sc_core_bench;
    localparam int MAW   = 6;
    localparam int WORDS = 1 << MAW;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           ld_en = 1'b0;
    logic           ld_dmem = 1'b0;
    logic [MAW-1:0] ld_addr = '0;
    logic [31:0]    ld_data = '0;
    logic [31:0]    pc_o;
    logic [4:0]     peek_reg = '0;
    logic [31:0]    peek_reg_data;
    logic [MAW-1:0] peek_addr = '0;
    logic [31:0]    peek_mem_data;

    always #10 clk = ~clk;

    sc_core #(.MEM_AW(MAW)) u_sc_core (
        .clk (clk), .rst (rst), .ld_en (ld_en), .ld_dmem (ld_dmem),
        .ld_addr (ld_addr), .ld_data (ld_data), .pc_o (pc_o),
        .peek_reg (peek_reg), .peek_reg_data (peek_reg_data),
        .peek_addr (peek_addr), .peek_mem_data (peek_mem_data)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [31:0] m_imem [WORDS];
    logic [31:0] m_dmem [WORDS];
    logic [31:0] m_reg  [32];
    logic [31:0] m_pc;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rd, input int rs, input int rt);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rt, input int rs, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // instruction-level reference
    task automatic m_step();
        logic [31:0] ins, a, b, addr, res, nxt;
        int rs, rt, rd;
        ins  = m_imem[m_pc[MAW+1:2]];
        rs   = int'(ins[25:21]);
        rt   = int'(ins[20:16]);
        rd   = int'(ins[15:11]);
        a    = m_reg[rs];
        b    = m_reg[rt];
        addr = a + sx(ins[15:0]);
        nxt  = m_pc + 32'd4;
        case (ins[31:26])
            6'b000000: begin
                bit wr = 1'b1;
                case (ins[5:0])
                    6'b100000: res = a + b;
                    6'b100010: res = a - b;
                    6'b100100: res = a & b;
                    6'b100101: res = a | b;
                    6'b101010: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: begin res = '0; wr = 1'b0; end
                endcase
                if (wr && rd != 0) m_reg[rd] = res;
            end
            6'b100011: if (rt != 0) m_reg[rt] = m_dmem[addr[MAW+1:2]];
            6'b101011: m_dmem[addr[MAW+1:2]] = b;
            6'b000100: if (a == b) nxt = m_pc + 32'd4 + {sx(ins[15:0]), 2'b00};
            default: ;
        endcase
        m_pc = nxt;
    endtask

    task automatic load_word(input bit to_d, input int idx, input logic [31:0] w);
        ld_en   = 1'b1;
        ld_dmem = to_d;
        ld_addr = MAW'(idx);
        ld_data = w;
        @(negedge clk);
        ld_en   = 1'b0;
    endtask

    task automatic run_prog(input string req, input int steps);
        rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < WORDS; i++) load_word(1'b0, i, m_imem[i]);
        for (int i = 0; i < WORDS; i++) load_word(1'b1, i, m_dmem[i]);
        for (int i = 0; i < 32; i++) m_reg[i] = '0;
        m_pc = '0;
        // R9: loading port and combinational inspection
        for (int i = 0; i < 4; i++) begin
            peek_addr = MAW'(i * 17);
            #0.05;
            chk("R9", "loaded data word", peek_mem_data, m_dmem[i * 17]);
        end
        // R1: reset state
        chk("R1", "pc in reset", pc_o, 32'd0);
        peek_reg = 5'd9;
        #0.05;
        chk("R1", "register in reset", peek_reg_data, 32'd0);
        rst = 1'b0;
        for (int s = 0; s < steps; s++) begin
            @(negedge clk);
            m_step();
        end
        chk(req, "pc after run", pc_o, m_pc);
        for (int r = 0; r < 32; r++) begin
            peek_reg = 5'(r);
            #0.05;
            chk(r == 0 ? "R7" : req, $sformatf("reg %0d", r), peek_reg_data, m_reg[r]);
        end
        for (int i = 0; i < WORDS; i++) begin
            peek_addr = MAW'(i);
            #0.05;
            chk(req, $sformatf("dmem %0d", i), peek_mem_data, m_dmem[i]);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < WORDS; i++) begin
            m_imem[i] = '0;
            m_dmem[i] = '0;
        end
    endtask

    function automatic logic [31:0] rand_instr();
        int k  = int'($urandom_range(0, 99));
        int rs = int'($urandom_range(0, 7));
        int rt = int'($urandom_range(0, 7));
        int rd = int'($urandom_range(0, 7));
        logic [5:0] fns [6] = '{6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010, 6'b000111};
        if (k < 40) return enc_r(fns[$urandom_range(0, 5)], rd, rs, rt);
        if (k < 65) return enc_i(6'b100011, rt, rs, int'($urandom_range(0, 600)) - 300);
        if (k < 80) return enc_i(6'b101011, rt, rs, int'($urandom_range(0, 600)) - 300);
        if (k < 93) return enc_i(6'b000100, rt, rs, int'($urandom_range(0, 15)) - 8);
        return {6'b111111, 26'($urandom)};
    endfunction

    initial begin
        void'($urandom(32'h5eed_0042));

        // R1: reset only
        clear_mem();
        run_prog("R1", 0);

        // R3 R4 R7 R8 R10: directed ALU, load, discard cases
        clear_mem();
        m_dmem[0] = 32'hFFFF_FFFB;
        m_dmem[1] = 32'd7;
        m_dmem[2] = 32'h8000_0000;
        m_imem[0]  = enc_i(6'b100011, 1, 0, 0);
        m_imem[1]  = enc_i(6'b100011, 2, 0, 5);       // R4 low bits ignored
        m_imem[2]  = enc_r(6'b100000, 3, 1, 2);
        m_imem[3]  = enc_r(6'b100010, 4, 1, 2);
        m_imem[4]  = enc_r(6'b100100, 5, 1, 2);
        m_imem[5]  = enc_r(6'b100101, 6, 1, 2);
        m_imem[6]  = enc_r(6'b101010, 7, 1, 2);       // signed -5 < 7
        m_imem[7]  = enc_r(6'b101010, 8, 2, 1);
        m_imem[8]  = enc_r(6'b100000, 0, 1, 2);       // R7 write to r0
        m_imem[9]  = enc_r(6'b000111, 9, 1, 2);       // R3 unknown funct
        m_imem[10] = 32'hFC22_0001;                   // R8 unused opcode
        m_imem[11] = enc_r(6'b100000, 2, 2, 2);       // R10 old value used
        m_imem[12] = enc_i(6'b100011, 10, 0, 8);
        m_imem[13] = enc_r(6'b101010, 11, 10, 2);
        run_prog("R3", 14);
        peek_reg = 5'd7;
        #0.05;
        chk("R3", "slt negative", peek_reg_data, 32'd1);
        peek_reg = 5'd2;
        #0.05;
        chk("R10", "self add", peek_reg_data, 32'd14);

        // R5 R6: store and branch loop
        clear_mem();
        m_dmem[0] = 32'd1;
        m_dmem[1] = 32'd3;
        m_imem[0] = enc_i(6'b100011, 1, 0, 0);
        m_imem[1] = enc_i(6'b100011, 2, 0, 4);
        m_imem[2] = enc_r(6'b100000, 3, 3, 1);
        m_imem[3] = enc_i(6'b000100, 2, 3, 1);        // exit when r3==r2
        m_imem[4] = enc_i(6'b000100, 0, 0, -3);       // back to add
        m_imem[5] = enc_i(6'b101011, 3, 0, 40);
        m_imem[6] = enc_i(6'b101011, 1, 1, -1);       // addr 0 -> word 0
        run_prog("R6", 14);
        peek_addr = MAW'(10);
        #0.05;
        chk("R5", "stored word", peek_mem_data, 32'd3);
        chk("R2", "pc after wrap of program", pc_o, m_pc);

        // random programs
        for (int t = 0; t < 30; t++) begin
            for (int i = 0; i < WORDS; i++) begin
                m_imem[i] = rand_instr();
                m_dmem[i] = (i % 5 == 0) ? 32'($urandom_range(0, 255)) : $urandom;
            end
            run_prog(t % 2 == 0 ? "R4" : "R2", 40 + t);
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20.0 * 190000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule